// File: doc/BRIEF.md
# DC-Balance Word Encoder

This block sits on the transmit side of one serial lane, ahead of the shifter. On each word-clock cycle with `inValid` high it takes a 7-bit parallel word and produces a 9-bit coded symbol. The symbol carries the payload either as given or bitwise inverted, plus two flag bits that are always complements of each other. The flags tell the far end which form was sent, so the receiver can recover the original word.

The choice between true and inverted payload follows a signed running digital sum. In that sum every transmitted 1 counts +1 and every 0 counts -1. When the sum is nonzero and the incoming word's own disparity has the same sign, the payload is inverted, which pulls the sum back toward zero. When the sum is zero, or the signs differ, the payload goes out true. The flag pair adds no disparity of its own. The sum is exposed as a debug output so that line-balance behaviour can be observed.

The symbol is shifted out bit 0 first and bit 8 last. Under this order the lane's running sum never moves outside ±10 at any bit position. At word boundaries it stays within ±7.

Top module: `dcb_word_encoder`

## Requirements
- R1: While `rstN` is low, `outValid`, `outSymbol` and `runSum` are all 0.
- R2: `outValid` equals the value `inValid` had at the previous rising clock edge.
- R3: A word is inverted exactly when `runSum` is nonzero and the word's disparity (twice its count of ones minus 7) has the same sign as `runSum`. Otherwise the word is sent true.
- R4: Symbol bit 7 is 1 and bit 8 is 0 for an inverted payload. Bit 7 is 0 and bit 8 is 1 for a true payload, so the two flags always differ.
- R5: Symbol bits 6..0 hold the accepted word, either unchanged or bitwise complemented according to R3. Input bit i maps to symbol bit i.
- R6: On each accepted word, `runSum` advances by the disparity of the 9 bits actually sent. While `inValid` is low, both `runSum` and `outSymbol` keep their values.
- R7: At word boundaries `runSum` stays within ±7. When a symbol is shifted bit 0 first, the lane's running sum stays within ±10 at every bit position.
- R8: Complementing bits 6..0 whenever bit 7 is 1 restores the original input word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Word clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Qualifies `inWord` for this cycle |
| inWord | input | 7 | Parallel payload word |
| outValid | output | 1 | A new symbol was produced on the last edge |
| outSymbol | output | 9 | Coded symbol: payload in 6..0, inversion flag in 7, complement flag in 8 |
| runSum | output | 5 | Signed running digital sum after the last symbol sent (debug) |

## Verification
The assertions check several properties on every cycle. The flag bits must be complementary. The change in `runSum` must match the ones count of the emitted symbol. The sum must hold between valid words and stay within its boundary bound. No inversion may happen from a zero sum, and valid must track its input with one cycle of delay. Other behaviour can only be shown by the bench's scenarios. These include the exact invert decision for each sign combination, recovery of the original word, and the ±10 limit at intermediate bit positions. They are exercised by worst-case runs of all-ones, all-zeros and front-loaded words, by alternating runs, by random streams with idle gaps, and by a mid-run reset.

// File: rtl/dcb_enc_pkg.sv
package dcb_enc_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic invert;
  } dcb_strobe_t;
endpackage

// File: rtl/dcb_enc_ctrl.sv
module dcb_enc_ctrl
  import dcb_enc_pkg::*;
#(
  parameter int DataWidth = 7,
  parameter int SumWidth  = 5
) (
  input  logic                       inValid,
  input  logic [DataWidth-1:0]       inWord,
  input  logic signed [SumWidth-1:0] runSum,
  output dcb_strobe_t                strobe,
  output logic signed [SumWidth-1:0] wordDisp
);
  localparam int CntWidth = $clog2(DataWidth + 1);

  logic [CntWidth-1:0] onesCnt;
  logic sameSign;

  // ones count of the incoming word
  always_comb begin
    onesCnt = '0;
    for (int i = 0; i < DataWidth; i++) begin
      onesCnt = onesCnt + CntWidth'(inWord[i]);
    end
  end

  // disparity = ones - zeros
  always_comb begin
    int dispInt;
    dispInt  = 2 * int'(onesCnt) - DataWidth;
    wordDisp = SumWidth'(dispInt);
  end

  // invert only when the word would push a nonzero sum further out
  always_comb begin
    sameSign = ((runSum > 0) && (wordDisp > 0)) ||
               ((runSum < 0) && (wordDisp < 0));
    strobe.load   = inValid;
    strobe.invert = inValid && sameSign;
  end
endmodule

// File: rtl/dcb_enc_datapath.sv
module dcb_enc_datapath
  import dcb_enc_pkg::*;
#(
  parameter int DataWidth = 7,
  parameter int SumWidth  = 5
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  dcb_strobe_t                 strobe,
  input  logic [DataWidth-1:0]        inWord,
  input  logic signed [SumWidth-1:0]  wordDisp,
  output logic                        outValid,
  output logic [DataWidth+1:0]        outSymbol,
  output logic signed [SumWidth-1:0]  runSum
);
  localparam int SymWidth = DataWidth + 2;

  logic signed [SumWidth-1:0] sentDisp;
  logic [DataWidth-1:0] payload;

  always_comb begin
    payload  = strobe.invert ? ~inWord : inWord;
    sentDisp = strobe.invert ? -wordDisp : wordDisp;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      outSymbol <= '0;
      runSum    <= '0;
    end else begin
      outValid <= strobe.load;
      if (strobe.load) begin
        outSymbol <= {~strobe.invert, strobe.invert, payload};
        runSum    <= runSum + sentDisp;
      end
    end
  end

  // flags always differ on a produced symbol
  assert_flag_pair_R4: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outSymbol[SymWidth-1] != outSymbol[SymWidth-2]));

  // sum steps by the disparity of what was sent
  assert_sum_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (int'(runSum) == int'($past(runSum)) + 2 * $countones(outSymbol) - SymWidth));

  // idle cycles leave state untouched
  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> ($stable(runSum) && $stable(outSymbol)));

  // inversion never chosen from a zero sum
  assert_zero_sum_true_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && runSum == 0) |=> !outSymbol[SymWidth-2]);

  // boundary sum bounded by the word width
  assert_sum_bound_R7: assert property (@(posedge clk) disable iff (!rstN)
    (int'(runSum) <= DataWidth) && (int'(runSum) >= -DataWidth));

  // one cycle from valid in to valid out
  assert_valid_latency_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> outValid);
endmodule

// File: rtl/dcb_word_encoder.sv
module dcb_word_encoder
  import dcb_enc_pkg::*;
#(
  parameter int DataWidth = 7,
  parameter int SumWidth  = 5
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       inValid,
  input  logic [DataWidth-1:0]       inWord,
  output logic                       outValid,
  output logic [DataWidth+1:0]       outSymbol,
  output logic signed [SumWidth-1:0] runSum
);
  dcb_strobe_t strobe;
  logic signed [SumWidth-1:0] wordDisp;

  dcb_enc_ctrl #(.DataWidth(DataWidth), .SumWidth(SumWidth)) ctrl_i (
    .inValid (inValid),
    .inWord  (inWord),
    .runSum  (runSum),
    .strobe  (strobe),
    .wordDisp(wordDisp)
  );

  dcb_enc_datapath #(.DataWidth(DataWidth), .SumWidth(SumWidth)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .inWord   (inWord),
    .wordDisp (wordDisp),
    .outValid (outValid),
    .outSymbol(outSymbol),
    .runSum   (runSum)
  );
endmodule

// File: tb/dcb_word_encoder_tb.sv
`timescale 1ns/1ps
module dcb_word_encoder_tb_top;
  localparam int DW = 7;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [DW-1:0] inWord = '0;
  logic outValid;
  logic [DW+1:0] outSymbol;
  logic signed [4:0] runSum;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // behavioural model state
  bit mValid = 0;
  bit mInv = 0;
  logic [DW+1:0] mSym = '0;
  int mSum = 0;
  int mPrevSum = 0;
  logic [DW-1:0] sentQ[$];

  always #2 clk = ~clk;

  dcb_word_encoder dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inWord(inWord),
    .outValid(outValid), .outSymbol(outSymbol), .runSum(runSum)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int disp(input logic [DW-1:0] w);
    int d = 0;
    for (int i = 0; i < DW; i++) d += w[i] ? 1 : -1;
    return d;
  endfunction

  task automatic compare();
    check(outValid == mValid, "R2 valid", int'(outValid), int'(mValid));
    check(int'(runSum) == mSum, "R6 sum", int'(runSum), mSum);
    check(outSymbol == mSym, "R6 symbol", int'(outSymbol), int'(mSym));
    check(int'(runSum) <= 7 && int'(runSum) >= -7, "R7 boundary", int'(runSum), 7);
    if (mValid) begin
      logic [DW-1:0] orig;
      logic [DW-1:0] dec;
      int walk;
      int peak;
      check(outSymbol[7] == mInv, "R3 invert", int'(outSymbol[7]), int'(mInv));
      check(outSymbol[8] != outSymbol[7], "R4 flags", int'(outSymbol[8:7]), mInv ? 1 : 2);
      orig = sentQ.pop_front();
      check(outSymbol[DW-1:0] == (mInv ? ~orig : orig), "R5 payload",
            int'(outSymbol[DW-1:0]), int'(mInv ? ~orig : orig));
      dec = outSymbol[7] ? ~outSymbol[DW-1:0] : outSymbol[DW-1:0];
      check(dec == orig, "R8 decode", int'(dec), int'(orig));
      walk = mPrevSum;
      peak = 0;
      for (int b = 0; b < DW + 2; b++) begin
        walk += outSymbol[b] ? 1 : -1;
        if (walk > peak) peak = walk;
        if (-walk > peak) peak = -walk;
      end
      check(peak <= 10, "R7 serial", peak, 10);
    end
  endtask

  task automatic step(input bit v, input logic [DW-1:0] w);
    @(negedge clk);
    compare();
    inValid = v;
    inWord = w;
    mValid = v;
    if (v) begin
      int d;
      d = disp(w);
      mInv = (mSum > 0 && d > 0) || (mSum < 0 && d < 0);
      mSym = {~mInv, mInv, mInv ? ~w : w};
      mPrevSum = mSum;
      mSum += mInv ? -d : d;
      sentQ.push_back(w);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 0;
    inValid = 0;
    mValid = 0; mInv = 0; mSym = '0; mSum = 0; mPrevSum = 0;
    sentQ.delete();
    repeat (2) @(negedge clk);
    // R1: state cleared during reset
    check(outValid == 0, "R1 valid", int'(outValid), 0);
    check(outSymbol == 0, "R1 symbol", int'(outSymbol), 0);
    check(runSum == 0, "R1 sum", int'(runSum), 0);
    rstN = 1;
  endtask

  initial begin
    doReset();
    // zero sum sends true, then same-sign word inverts (R3)
    step(1, 7'b1111111);
    step(1, 7'b1111111);
    step(1, 7'b1111111);
    step(0, 7'b0000000);
    step(1, 7'b0000000);
    step(1, 7'b0000000);
    // worst-case front-loaded ones and zeros (R7)
    for (int i = 0; i < 40; i++) step(1, (i % 2) ? 7'b0000111 : 7'b1111111);
    for (int i = 0; i < 40; i++) step(1, (i % 2) ? 7'b1111000 : 7'b0000000);
    for (int i = 0; i < 40; i++) step(1, (i % 3 == 0) ? 7'b0000111 : 7'b1111000);
    // idle gaps hold state (R6)
    step(1, 7'b1010101);
    for (int i = 0; i < 5; i++) step(0, 7'(i * 17));
    // random stream with gaps
    for (int i = 0; i < 3000; i++) step(($urandom % 4) != 0, 7'($urandom));
    // mid-run reset
    doReset();
    for (int i = 0; i < 200; i++) step(1, 7'($urandom));
    step(0, '0);
    step(0, '0);
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule